// File: doc/BRIEF.md
# Endpoint-0 Control Transfer Stage Sequencer

This block follows a USB control transfer on endpoint 0 from its opening SETUP packet to the end of its zero-length status handshake. It serves a device with one configuration and one interface. Each received or transmitted packet is reported to it as a one-cycle event that carries a kind and a byte count. Firmware reports the end of each stage with a one-cycle acknowledge pulse. The sequencer shows the current stage, the direction expected for the data stage and for the status stage, and a protocol-error flag.

When a SETUP packet arrives, the block decodes the 8-byte request. It extracts the direction bit, the request code and the 16-bit requested length. It also raises a flag when a standard request asks for a configuration or an alternate interface setting that the device does not have, so that firmware treats the request as a no-op. The block does not receive packets and does not hold the packet buffers.

State machine: `S_IDLE` (stage idle), `S_SETUP_HOLD` (setup received, waiting for the acknowledge), `S_DATA_WAIT` (waiting for a data packet), `S_DATA_HOLD` (data packet seen, waiting for the acknowledge), `S_STAT_WAIT` (waiting for the status packet) and `S_STAT_HOLD` (status packet seen, waiting for the acknowledge). The transitions are:
- SETUP from any state goes to `S_SETUP_HOLD`.
- From `S_SETUP_HOLD`, the acknowledge goes to `S_DATA_WAIT` when data is requested and to `S_STAT_WAIT` when it is not.
- From `S_DATA_WAIT`, a packet in the right direction goes to `S_DATA_HOLD`.
- From `S_DATA_HOLD`, the acknowledge goes to `S_STAT_WAIT` when the transfer is complete and back to `S_DATA_WAIT` when it is not.
- From `S_STAT_WAIT`, a correct status packet goes to `S_STAT_HOLD`.
- From `S_STAT_HOLD`, the acknowledge goes to `S_IDLE`.
- Any error goes to `S_IDLE`.

Top module: `ep0_stage_seq`

## Requirements
- R1: After reset, `stage` is 0 (idle), `proto_err` is 0 and `status_dir_in` is 1.
- R2: A packet event of kind 0 (SETUP) moves `stage` to 1 (setup) one edge later, from any state. It also clears `proto_err` and captures the request.
- R3: The captured request is decoded as follows. `req_dir_in` is bit 7 of byte 0. `req_code` is byte 1. `req_len` is bytes 6 (low) and 7 (high). Byte k of the setup bus sits at bits 8k+7:8k.
- R4: An acknowledge during the setup stage moves to stage 2 (data) when `req_len` is non-zero, and to stage 3 (status) when it is zero.
- R5: The stage never advances without an acknowledge. While an acknowledge is awaited and no packet arrives, the stage holds.
- R6: In the data stage, packets of kind 2 (IN) are expected when `data_dir_in` is 1, and packets of kind 1 (OUT) when it is 0. After the acknowledge, the block moves to status once the bytes moved reach `req_len` or a packet shorter than 8 bytes was seen. Otherwise it stays in data.
- R7: `status_dir_in` is the inverse of `data_dir_in` when `req_len` is non-zero, and 1 (IN) when it is zero.
- R8: In the status stage, only a zero-length packet in the status direction is accepted. The acknowledge that follows returns the stage to 0.
- R9: Any of the following sets `proto_err` and returns the stage to 0: a packet of the wrong kind, a status packet with a non-zero length, or any non-SETUP packet while an acknowledge is awaited. The flag stays set until the next SETUP.
- R10: `req_ignore` is 1 when the request type bits 6:5 are 0 (standard) and either of these holds: the code is 9 (set configuration) with a value byte (byte 2) above 1, or the code is 11 (set interface) with a non-zero value. Otherwise it is 0.
- R11: Non-SETUP packets and acknowledges in the idle stage are ignored. The stage stays 0 and `proto_err` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_valid | input | 1 | One-cycle packet event |
| pkt_kind | input | 2 | 0 SETUP, 1 OUT, 2 IN, 3 reserved |
| pkt_len | input | 4 | Packet byte count, 0 to 8 |
| setup_bytes | input | 64 | Setup request, byte k at bits 8k+7:8k, valid with a SETUP event |
| fw_ack | input | 1 | Firmware end-of-stage acknowledge |
| stage | output | 2 | 0 idle, 1 setup, 2 data, 3 status |
| data_dir_in | output | 1 | Data stage runs device to host |
| status_dir_in | output | 1 | Status stage runs device to host |
| proto_err | output | 1 | Protocol error, held until next SETUP |
| req_dir_in | output | 1 | Decoded direction bit |
| req_code | output | 8 | Decoded request code |
| req_len | output | 16 | Decoded requested length |
| req_ignore | output | 1 | Request selects an unsupported configuration or setting |

## Verification
Every result is registered. The stage, the error flag and the decoded request fields change on the first rising edge that samples the stimulus. The direction outputs follow the captured request on that same edge. The bench drives each event on a falling edge, removes it at the next falling edge, and reads the outputs there: exactly one rising edge later, when they are settled. The hold checks add idle cycles between events and sample after each one, so that an early or spontaneous change would be caught.

// File: rtl/ep0_seq_pkg.sv
package ep0_seq_pkg;

    typedef enum logic [1:0] {
        PK_SETUP = 2'd0,
        PK_OUT   = 2'd1,
        PK_IN    = 2'd2,
        PK_RSVD  = 2'd3
    } pkt_kind_e;

    typedef enum logic [1:0] {
        STG_IDLE   = 2'd0,
        STG_SETUP  = 2'd1,
        STG_DATA   = 2'd2,
        STG_STATUS = 2'd3
    } stage_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP_HOLD,
        S_DATA_WAIT,
        S_DATA_HOLD,
        S_STAT_WAIT,
        S_STAT_HOLD
    } fsm_e;

    typedef struct packed {
        logic        dir_in;
        logic [7:0]  code;
        logic [15:0] wlen;
        logic        ignore;
    } req_t;

    localparam logic [7:0] REQ_SET_CFG = 8'd9;
    localparam logic [7:0] REQ_SET_IF  = 8'd11;

endpackage

// File: rtl/ep0_setup_decode.sv
module ep0_setup_decode
    import ep0_seq_pkg::*;
#(
    parameter int SETUP_BYTES = 8
) (
    input  logic [SETUP_BYTES*8-1:0] raw,
    output req_t                     req
);
    logic [7:0] byte_q [SETUP_BYTES];

    for (genvar g = 0; g < SETUP_BYTES; g++) begin : g_bytes
        assign byte_q[g] = raw[g*8 +: 8];
    end

    logic is_std;
    logic bad_cfg;
    logic bad_alt;

    always_comb begin
        is_std     = (byte_q[0][6:5] == 2'b00);
        bad_cfg    = (byte_q[1] == REQ_SET_CFG) && (byte_q[2] > 8'd1);
        bad_alt    = (byte_q[1] == REQ_SET_IF) && (byte_q[2] != 8'd0);
        req.dir_in = byte_q[0][7];
        req.code   = byte_q[1];
        req.wlen   = {byte_q[7], byte_q[6]};
        req.ignore = is_std && (bad_cfg || bad_alt);
    end
endmodule

// File: rtl/ep0_byte_tracker.sv
module ep0_byte_tracker #(
    parameter int MAX_PKT = 8,
    parameter int CNT_W   = 16,
    localparam int LEN_W  = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             add,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [CNT_W-1:0] want_len,
    output logic             done
);
    logic [CNT_W:0] moved;
    logic [CNT_W:0] sum;

    assign sum = moved + (CNT_W+1)'(pkt_len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            moved <= '0;
            done  <= 1'b0;
        end else if (clear) begin
            moved <= '0;
            done  <= 1'b0;
        end else if (add) begin
            moved <= sum;
            done  <= (sum >= {1'b0, want_len}) || (pkt_len < LEN_W'(MAX_PKT));
        end
    end
endmodule

// File: rtl/ep0_stage_fsm.sv
module ep0_stage_fsm
    import ep0_seq_pkg::*;
#(
    parameter int MAX_PKT = 8,
    localparam int LEN_W  = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_valid,
    input  logic [1:0]       pkt_kind,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             fw_ack,
    input  logic             has_data,
    input  logic             data_in,
    input  logic             stat_in,
    input  logic             xfer_done,
    output logic             capture,
    output logic             track_add,
    output stage_e           stage,
    output logic             proto_err
);
    fsm_e      st, nxt;
    logic      err_evt;
    pkt_kind_e want_data, want_stat;

    assign want_data = data_in ? PK_IN : PK_OUT;
    assign want_stat = stat_in ? PK_IN : PK_OUT;
    assign capture   = pkt_valid && (pkt_kind == PK_SETUP);

    always_comb begin
        nxt       = st;
        err_evt   = 1'b0;
        track_add = 1'b0;
        if (capture) begin
            nxt = S_SETUP_HOLD;
        end else begin
            unique case (st)
                S_IDLE: nxt = S_IDLE;
                S_SETUP_HOLD: begin
                    if (pkt_valid)   err_evt = 1'b1;
                    else if (fw_ack) nxt = has_data ? S_DATA_WAIT : S_STAT_WAIT;
                end
                S_DATA_WAIT: begin
                    if (pkt_valid) begin
                        if (pkt_kind == want_data) begin
                            track_add = 1'b1;
                            nxt       = S_DATA_HOLD;
                        end else begin
                            err_evt = 1'b1;
                        end
                    end
                end
                S_DATA_HOLD: begin
                    if (pkt_valid)   err_evt = 1'b1;
                    else if (fw_ack) nxt = xfer_done ? S_STAT_WAIT : S_DATA_WAIT;
                end
                S_STAT_WAIT: begin
                    if (pkt_valid) begin
                        if ((pkt_kind == want_stat) && (pkt_len == '0)) nxt = S_STAT_HOLD;
                        else err_evt = 1'b1;
                    end
                end
                S_STAT_HOLD: begin
                    if (pkt_valid)   err_evt = 1'b1;
                    else if (fw_ack) nxt = S_IDLE;
                end
                default: nxt = S_IDLE;
            endcase
            if (err_evt) nxt = S_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            proto_err <= 1'b0;
        end else begin
            st <= nxt;
            if (capture)      proto_err <= 1'b0;
            else if (err_evt) proto_err <= 1'b1;
        end
    end

    // stage output
    always_comb begin
        unique case (st)
            S_SETUP_HOLD:             stage = STG_SETUP;
            S_DATA_WAIT, S_DATA_HOLD: stage = STG_DATA;
            S_STAT_WAIT, S_STAT_HOLD: stage = STG_STATUS;
            default:                  stage = STG_IDLE;
        endcase
    end
endmodule

// File: rtl/ep0_stage_seq.sv
module ep0_stage_seq
    import ep0_seq_pkg::*;
#(
    parameter int SETUP_BYTES = 8,
    parameter int MAX_PKT     = 8,
    parameter int CNT_W       = 16,
    localparam int LEN_W      = $clog2(MAX_PKT + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pkt_valid,
    input  logic [1:0]               pkt_kind,
    input  logic [LEN_W-1:0]         pkt_len,
    input  logic [SETUP_BYTES*8-1:0] setup_bytes,
    input  logic                     fw_ack,
    output logic [1:0]               stage,
    output logic                     data_dir_in,
    output logic                     status_dir_in,
    output logic                     proto_err,
    output logic                     req_dir_in,
    output logic [7:0]               req_code,
    output logic [15:0]              req_len,
    output logic                     req_ignore
);
    req_t   dec, req_q;
    logic   capture, track_add, xfer_done, has_data;
    stage_e stage_e_q;

    ep0_setup_decode #(.SETUP_BYTES(SETUP_BYTES)) u_dec (
        .raw (setup_bytes),
        .req (dec)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       req_q <= '0;
        else if (capture) req_q <= dec;
    end

    assign has_data      = (req_q.wlen != 16'd0);
    assign data_dir_in   = req_q.dir_in;
    assign status_dir_in = has_data ? ~req_q.dir_in : 1'b1;

    ep0_byte_tracker #(.MAX_PKT(MAX_PKT), .CNT_W(CNT_W)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (capture),
        .add      (track_add),
        .pkt_len  (pkt_len),
        .want_len (CNT_W'(req_q.wlen)),
        .done     (xfer_done)
    );

    ep0_stage_fsm #(.MAX_PKT(MAX_PKT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_valid (pkt_valid),
        .pkt_kind  (pkt_kind),
        .pkt_len   (pkt_len),
        .fw_ack    (fw_ack),
        .has_data  (has_data),
        .data_in   (req_q.dir_in),
        .stat_in   (status_dir_in),
        .xfer_done (xfer_done),
        .capture   (capture),
        .track_add (track_add),
        .stage     (stage_e_q),
        .proto_err (proto_err)
    );

    assign stage      = stage_e_q;
    assign req_dir_in = req_q.dir_in;
    assign req_code   = req_q.code;
    assign req_len    = req_q.wlen;
    assign req_ignore = req_q.ignore;
endmodule

// File: rtl/ep0_stage_seq_chk.sv
module ep0_stage_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pkt_valid,
    input logic [1:0]  pkt_kind,
    input logic        fw_ack,
    input logic [1:0]  stage,
    input logic        data_dir_in,
    input logic        status_dir_in,
    input logic        proto_err,
    input logic [15:0] req_len
);
    AST_SETUP_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_kind == 2'd0) |=> (stage == 2'd1 && !proto_err)); // R2

    AST_NODATA_TO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 2'd1 && fw_ack && !pkt_valid && req_len == 16'd0) |=> (stage == 2'd3)); // R4

    AST_SETUP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 2'd1 && !fw_ack && !pkt_valid) |=> (stage == 2'd1)); // R5

    AST_STATUS_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 2'd3 && req_len != 16'd0) |-> (status_dir_in != data_dir_in)); // R7

    AST_ERR_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proto_err) |-> (stage == 2'd0)); // R9

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 2'd0 && !(pkt_valid && pkt_kind == 2'd0)) |=> (stage == 2'd0 && $stable(proto_err))); // R11
endmodule

bind ep0_stage_seq ep0_stage_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pkt_valid     (pkt_valid),
    .pkt_kind      (pkt_kind),
    .fw_ack        (fw_ack),
    .stage         (stage),
    .data_dir_in   (data_dir_in),
    .status_dir_in (status_dir_in),
    .proto_err     (proto_err),
    .req_len       (req_len)
);

// File: tb/ep0_stage_seq_tb.sv
module ep0_stage_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_valid = 1'b0;
    logic [1:0]  pkt_kind = 2'd0;
    logic [3:0]  pkt_len = 4'd0;
    logic [63:0] setup_bytes = '0;
    logic        fw_ack = 1'b0;
    logic [1:0]  stage;
    logic        data_dir_in, status_dir_in, proto_err, req_dir_in, req_ignore;
    logic [7:0]  req_code;
    logic [15:0] req_len;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ep0_stage_seq u_dut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_kind(pkt_kind),
        .pkt_len(pkt_len), .setup_bytes(setup_bytes), .fw_ack(fw_ack),
        .stage(stage), .data_dir_in(data_dir_in), .status_dir_in(status_dir_in),
        .proto_err(proto_err), .req_dir_in(req_dir_in), .req_code(req_code),
        .req_len(req_len), .req_ignore(req_ignore)
    );

    // {valid, kind[1:0], len[3:0], ack, exp_stage[1:0], exp_err, exp_sdir}
    localparam int NV = 16;
    localparam logic [11:0] VEC [NV] = '{
        {1'b1, 2'd0, 4'd8, 1'b0, 2'd1, 1'b0, 1'b0},
        {1'b0, 2'd0, 4'd0, 1'b1, 2'd2, 1'b0, 1'b0},
        {1'b1, 2'd2, 4'd8, 1'b0, 2'd2, 1'b0, 1'b0},
        {1'b0, 2'd0, 4'd0, 1'b1, 2'd2, 1'b0, 1'b0},
        {1'b1, 2'd2, 4'd8, 1'b0, 2'd2, 1'b0, 1'b0},
        {1'b0, 2'd0, 4'd0, 1'b1, 2'd2, 1'b0, 1'b0},
        {1'b1, 2'd2, 4'd2, 1'b0, 2'd2, 1'b0, 1'b0},
        {1'b0, 2'd0, 4'd0, 1'b1, 2'd3, 1'b0, 1'b0},
        {1'b1, 2'd1, 4'd0, 1'b0, 2'd3, 1'b0, 1'b0},
        {1'b0, 2'd0, 4'd0, 1'b1, 2'd0, 1'b0, 1'b0},
        {1'b1, 2'd0, 4'd8, 1'b0, 2'd1, 1'b0, 1'b0},
        {1'b0, 2'd0, 4'd0, 1'b1, 2'd2, 1'b0, 1'b0},
        {1'b1, 2'd1, 4'd8, 1'b0, 2'd0, 1'b1, 1'b0},
        {1'b0, 2'd0, 4'd0, 1'b1, 2'd0, 1'b1, 1'b0},
        {1'b1, 2'd0, 4'd8, 1'b0, 2'd1, 1'b0, 1'b0},
        {1'b1, 2'd2, 4'd8, 1'b0, 2'd0, 1'b1, 1'b0}
    };

    task automatic chk(input int act, input int exp, input string tag);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] k, input logic [3:0] l, input logic a);
        @(negedge clk);
        pkt_valid = v; pkt_kind = k; pkt_len = l; fw_ack = a;
        @(negedge clk);
        pkt_valid = 1'b0; fw_ack = 1'b0;
    endtask

    task automatic setup(input logic [63:0] b);
        setup_bytes = b;
        step(1'b1, 2'd0, 4'd8, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(stage, 0, "R1 stage");
        chk(proto_err, 0, "R1 err");
        chk(status_dir_in, 1, "R1 sdir");
        rst_n = 1'b1;

        // table: IN read of 18 bytes, then direction error cases (R2 R4 R6 R8 R9)
        setup_bytes = 64'h0012_0000_0100_0680;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][11], VEC[i][10:9], VEC[i][8:5], VEC[i][4]);
            chk(stage, VEC[i][3:2], $sformatf("R6/R8/R9 vec%0d stage", i));
            chk(proto_err, VEC[i][1], $sformatf("R2/R9 vec%0d err", i));
            chk(status_dir_in, VEC[i][0], $sformatf("R7 vec%0d sdir", i));
        end

        // no-data request: decode, skip to status, status is IN
        setup(64'h0000_0000_0007_0500);
        chk(stage, 1, "R2 setup after err");
        chk(proto_err, 0, "R2 err cleared");
        chk(req_code, 5, "R3 code");
        chk(req_len, 0, "R3 len");
        chk(req_dir_in, 0, "R3 dir");
        step(1'b0, 2'd0, 4'd0, 1'b1);
        chk(stage, 3, "R4 skip data");
        chk(status_dir_in, 1, "R7 no data IN");
        step(1'b1, 2'd2, 4'd0, 1'b0);
        chk(stage, 3, "R8 status pkt");
        step(1'b0, 2'd0, 4'd0, 1'b1);
        chk(stage, 0, "R8 done");
        step(1'b1, 2'd1, 4'd8, 1'b0);
        chk(stage, 0, "R11 idle OUT");
        chk(proto_err, 0, "R11 idle err");
        step(1'b0, 2'd0, 4'd0, 1'b1);
        chk(stage, 0, "R11 idle ack");

        // OUT data of 8 bytes, hold checks, bad status length
        setup(64'h0008_0000_0000_0140);
        chk(req_len, 8, "R3 len8");
        chk(req_dir_in, 0, "R3 dir out");
        repeat (3) @(negedge clk);
        chk(stage, 1, "R5 setup hold");
        step(1'b0, 2'd0, 4'd0, 1'b1);
        chk(stage, 2, "R4 to data");
        chk(data_dir_in, 0, "R6 data dir");
        step(1'b1, 2'd1, 4'd8, 1'b0);
        repeat (3) @(negedge clk);
        chk(stage, 2, "R5 data hold");
        step(1'b0, 2'd0, 4'd0, 1'b1);
        chk(stage, 3, "R6 count reached");
        chk(status_dir_in, 1, "R7 OUT->IN");
        step(1'b1, 2'd2, 4'd3, 1'b0);
        chk(stage, 0, "R9 status len");
        chk(proto_err, 1, "R9 status len err");

        // short packet ends data; SETUP aborts mid-data
        setup(64'h0040_0000_0200_0680);
        chk(req_len, 64, "R3 len64");
        step(1'b0, 2'd0, 4'd0, 1'b1);
        step(1'b1, 2'd2, 4'd5, 1'b0);
        step(1'b0, 2'd0, 4'd0, 1'b1);
        chk(stage, 3, "R6 short pkt");
        setup(64'h0040_0000_0200_0680);
        step(1'b0, 2'd0, 4'd0, 1'b1);
        chk(stage, 2, "R4 data again");
        setup(64'h0040_0000_0200_0680);
        chk(stage, 1, "R2 abort data");

        // suppression decode
        setup(64'h0000_0000_0002_0900);
        chk(req_ignore, 1, "R10 cfg2");
        setup(64'h0000_0000_0001_0900);
        chk(req_ignore, 0, "R10 cfg1");
        setup(64'h0000_0000_0001_0B01);
        chk(req_ignore, 1, "R10 alt1");
        setup(64'h0000_0000_0000_0B01);
        chk(req_ignore, 0, "R10 alt0");
        setup(64'h0000_0000_0002_0940);
        chk(req_ignore, 0, "R10 vendor");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule